// File: doc/BRIEF.md
# NAND Block-Erase Sequencer

This block is the host-side engine that wipes one erase block of an 8-bit NAND page memory. Higher logic pulses a start request together with a 10-bit block number. The sequencer then drives the command-latch, address-latch, chip-enable, write and read strobes and the 8-bit data bus through a fixed order of steps. It first issues the erase setup command and then the two row-address bytes. Next comes the confirm command, after which it waits on the open-drain ready/busy line. It then issues a status command and reads back one status byte.

Each block holds 16 pages, so the row sent to the memory is the block number shifted left by four. When the sequence ends, a one-cycle done pulse comes with a pass flag and a retire flag. The retire flag tells the caller that the memory reported an erase error, so the block should be mapped out. A busy timeout guards against a memory that never comes ready again. Every strobe phase lasts a set number of clock cycles, so the latch setup and hold margins come from parameters.

Top module: `nand_blk_erase`

## Requirements
- R1: After reset, cle_o and ale_o are 0, ce_n_o, we_n_o and re_n_o are 1, wp_n_o is 0, and busy_o, done_o, pass_o and bad_blk_o are 0.
- R2: A start pulse while idle raises busy_o and drives ce_n_o low and wp_n_o high for the whole operation. After done_o, busy_o is 0, ce_n_o is 1 and wp_n_o is 0.
- R3: The write cycles come in this order: 60h with cle_o=1, then the row bits [7:0] with ale_o=1, then the row bits [15:8] with ale_o=1, then D0h with cle_o=1, and after ready 70h with cle_o=1. The row is the block number times 16. cle_o and ale_o are never high together.
- R4: In every write cycle, cle_o, ale_o and io_o stay stable for at least SETUP_CYC cycles before we_n_o falls. we_n_o stays low for exactly PULSE_CYC cycles. The same signals stay stable for at least HOLD_CYC cycles after we_n_o rises.
- R5: After the confirm, the status command is issued only once rb_n_i has returned high. While rb_n_i stays low, the sequencer keeps waiting.
- R6: A status byte with bit 0 equal to 0 ends the operation with pass_o=1 and bad_blk_o=0. Bits 7..1 have no effect.
- R7: A status byte with bit 0 equal to 1 ends the operation with pass_o=0 and bad_blk_o=1.
- R8: If rb_n_i is not seen high within TIMEOUT_CYC cycles of entering the wait, the operation ends with pass_o=0 and bad_blk_o=0, and no status command is issued.
- R9: A start pulse while busy_o is 1 is ignored: the running operation keeps its block address and its order of steps.
- R10: we_n_o and re_n_o are never low together. io_oe_o is 1 whenever we_n_o is low and 0 whenever re_n_o is low.
- R11: done_o is high for exactly one cycle per operation. pass_o and bad_blk_o hold their values until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Erase request pulse |
| blk_addr_i | input | BLK_W | Block number to erase |
| rb_n_i | input | 1 | Memory ready (1) / busy (0), asynchronous |
| io_i | input | 8 | Data bus from memory |
| io_o | output | 8 | Data bus to memory |
| io_oe_o | output | 1 | Bus drive enable |
| cle_o | output | 1 | Command latch strobe |
| ale_o | output | 1 | Address latch strobe |
| ce_n_o | output | 1 | Chip enable, active low |
| we_n_o | output | 1 | Write strobe, active low |
| re_n_o | output | 1 | Read strobe, active low |
| wp_n_o | output | 1 | Write protect, high while the operation runs |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| pass_o | output | 1 | Erase succeeded |
| bad_blk_o | output | 1 | Memory reported an erase error; retire the block |

## Verification
A wrong sequencer state shows at the ports within one bus cycle. The bench would see a command or address byte out of order, a wrong row byte, or a status command issued while rb_n_i is still low, and it sees these at the next rising edge of we_n_o. A miscounted strobe phase shows as a wrong write pulse width or a short setup or hold window around that same edge. A wrong result decode or a timer fault shows in the cycle where done_o pulses, as a wrong pass or retire flag, or as a timeout that fires early or too late.

// File: rtl/nand_erase_pkg.sv
package nand_erase_pkg;

    localparam logic [7:0] CMD_ERASE_SETUP = 8'h60;
    localparam logic [7:0] CMD_ERASE_GO    = 8'hD0;
    localparam logic [7:0] CMD_STATUS      = 8'h70;

    localparam int ROW_BYTES = 2;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SETUP,
        ST_ADDR_LO,
        ST_ADDR_HI,
        ST_CONFIRM,
        ST_WAIT,
        ST_STAT_CMD,
        ST_STAT_RD
    } seq_state_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SETUP,
        PH_STROBE,
        PH_HOLD
    } bus_phase_e;

    typedef struct packed {
        logic       rd;
        logic       cle;
        logic       ale;
        logic [7:0] data;
    } bus_op_t;

    function automatic logic [7:0] row_byte(input logic [8*ROW_BYTES-1:0] row, input logic hi);
        return hi ? row[15:8] : row[7:0];
    endfunction

    function automatic bus_op_t cmd_op(input logic [7:0] code);
        bus_op_t op;
        op      = '0;
        op.cle  = 1'b1;
        op.data = code;
        return op;
    endfunction

endpackage

// File: rtl/nand_bus_cycle.sv
module nand_bus_cycle
    import nand_erase_pkg::*;
#(
    parameter int SETUP_CYC = 2,
    parameter int PULSE_CYC = 3,
    parameter int HOLD_CYC  = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       req_i,
    input  bus_op_t    op_i,
    input  logic [7:0] io_i,
    output logic       cle_o,
    output logic       ale_o,
    output logic       we_n_o,
    output logic       re_n_o,
    output logic [7:0] io_o,
    output logic       io_oe_o,
    output logic [7:0] rdata_o,
    output logic       ack_o
);

    localparam int CW = $clog2(SETUP_CYC + PULSE_CYC + HOLD_CYC + 1) + 1;
    localparam logic [CW-1:0] SETUP_LAST = CW'(SETUP_CYC - 1);
    localparam logic [CW-1:0] PULSE_LAST = CW'(PULSE_CYC - 1);
    localparam logic [CW-1:0] HOLD_LAST  = CW'(HOLD_CYC - 1);

    bus_phase_e    phase_q;
    logic [CW-1:0] cnt_q;
    logic          rd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            rd_q    <= 1'b0;
            cle_o   <= 1'b0;
            ale_o   <= 1'b0;
            we_n_o  <= 1'b1;
            re_n_o  <= 1'b1;
            io_o    <= '0;
            io_oe_o <= 1'b0;
            rdata_o <= '0;
            ack_o   <= 1'b0;
        end else begin
            ack_o <= 1'b0;
            case (phase_q)
                PH_IDLE: begin
                    if (req_i) begin
                        phase_q <= PH_SETUP;
                        cnt_q   <= '0;
                        rd_q    <= op_i.rd;
                        cle_o   <= op_i.cle;
                        ale_o   <= op_i.ale;
                        io_o    <= op_i.data;
                        io_oe_o <= ~op_i.rd;
                    end
                end
                PH_SETUP: begin
                    if (cnt_q == SETUP_LAST) begin
                        phase_q <= PH_STROBE;
                        cnt_q   <= '0;
                        we_n_o  <= rd_q;
                        re_n_o  <= ~rd_q;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                PH_STROBE: begin
                    if (cnt_q == PULSE_LAST) begin
                        phase_q <= PH_HOLD;
                        cnt_q   <= '0;
                        we_n_o  <= 1'b1;
                        re_n_o  <= 1'b1;
                        if (rd_q) begin
                            rdata_o <= io_i;
                        end
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                PH_HOLD: begin
                    if (cnt_q == HOLD_LAST) begin
                        phase_q <= PH_IDLE;
                        cnt_q   <= '0;
                        cle_o   <= 1'b0;
                        ale_o   <= 1'b0;
                        io_oe_o <= 1'b0;
                        ack_o   <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/nand_busy_timer.sv
module nand_busy_timer #(
    parameter int WB_CYC     = 4,
    parameter int TIMEOUT_CYC = 1000000
) (
    input  logic clk,
    input  logic rst,
    input  logic en_i,
    output logic wb_ok_o,
    output logic expired_o
);

    localparam int CNT_W = $clog2(TIMEOUT_CYC + 1) + 1;
    localparam logic [CNT_W-1:0] WB_LIM = CNT_W'(WB_CYC);
    localparam logic [CNT_W-1:0] TO_LIM = CNT_W'(TIMEOUT_CYC);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !en_i) begin
            cnt_q <= '0;
        end else if (cnt_q != TO_LIM) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign wb_ok_o   = en_i && (cnt_q >= WB_LIM);
    assign expired_o = en_i && (cnt_q >= TO_LIM);

endmodule

// File: rtl/nand_erase_fsm.sv
module nand_erase_fsm
    import nand_erase_pkg::*;
#(
    parameter int BLK_W = 10,
    parameter int PG_W  = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [BLK_W-1:0] blk_addr_i,
    input  logic             rb_rdy_i,
    input  logic             wb_ok_i,
    input  logic             expired_i,
    input  logic             ack_i,
    input  logic [7:0]       rdata_i,
    output logic             req_o,
    output bus_op_t          op_o,
    output logic             tmr_en_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             pass_o,
    output logic             bad_o,
    output logic             ce_n_o,
    output logic             wp_n_o
);

    localparam int ROW_W = 8 * ROW_BYTES;

    seq_state_e       state_q;
    logic [ROW_W-1:0] row_q;
    logic             bus_state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            row_q   <= '0;
            done_o  <= 1'b0;
            pass_o  <= 1'b0;
            bad_o   <= 1'b0;
            ce_n_o  <= 1'b1;
            wp_n_o  <= 1'b0;
        end else begin
            done_o <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        row_q   <= ROW_W'(blk_addr_i) << PG_W;
                        pass_o  <= 1'b0;
                        bad_o   <= 1'b0;
                        ce_n_o  <= 1'b0;
                        wp_n_o  <= 1'b1;
                        state_q <= ST_SETUP;
                    end
                end
                ST_SETUP:    if (ack_i) state_q <= ST_ADDR_LO;
                ST_ADDR_LO:  if (ack_i) state_q <= ST_ADDR_HI;
                ST_ADDR_HI:  if (ack_i) state_q <= ST_CONFIRM;
                ST_CONFIRM:  if (ack_i) state_q <= ST_WAIT;
                ST_WAIT: begin
                    if (expired_i) begin
                        pass_o  <= 1'b0;
                        bad_o   <= 1'b0;
                        done_o  <= 1'b1;
                        ce_n_o  <= 1'b1;
                        wp_n_o  <= 1'b0;
                        state_q <= ST_IDLE;
                    end else if (wb_ok_i && rb_rdy_i) begin
                        state_q <= ST_STAT_CMD;
                    end
                end
                ST_STAT_CMD: if (ack_i) state_q <= ST_STAT_RD;
                ST_STAT_RD: begin
                    if (ack_i) begin
                        pass_o  <= ~rdata_i[0];
                        bad_o   <= rdata_i[0];
                        done_o  <= 1'b1;
                        ce_n_o  <= 1'b1;
                        wp_n_o  <= 1'b0;
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        op_o      = '0;
        bus_state = 1'b1;
        case (state_q)
            ST_SETUP:    op_o = cmd_op(CMD_ERASE_SETUP);
            ST_ADDR_LO: begin
                op_o.ale  = 1'b1;
                op_o.data = row_byte(row_q, 1'b0);
            end
            ST_ADDR_HI: begin
                op_o.ale  = 1'b1;
                op_o.data = row_byte(row_q, 1'b1);
            end
            ST_CONFIRM:  op_o = cmd_op(CMD_ERASE_GO);
            ST_STAT_CMD: op_o = cmd_op(CMD_STATUS);
            ST_STAT_RD:  op_o.rd = 1'b1;
            default:     bus_state = 1'b0;
        endcase
    end

    assign req_o    = bus_state && !ack_i;
    assign tmr_en_o = (state_q == ST_WAIT);
    assign busy_o   = (state_q != ST_IDLE);

endmodule

// File: rtl/nand_blk_erase.sv
module nand_blk_erase
    import nand_erase_pkg::*;
#(
    parameter int BLK_W       = 10,
    parameter int PG_W        = 4,
    parameter int SETUP_CYC   = 2,
    parameter int PULSE_CYC   = 3,
    parameter int HOLD_CYC    = 2,
    parameter int WB_CYC      = 4,
    parameter int TIMEOUT_CYC = 1000000,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [BLK_W-1:0] blk_addr_i,
    input  logic             rb_n_i,
    input  logic [7:0]       io_i,
    output logic [7:0]       io_o,
    output logic             io_oe_o,
    output logic             cle_o,
    output logic             ale_o,
    output logic             ce_n_o,
    output logic             we_n_o,
    output logic             re_n_o,
    output logic             wp_n_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             pass_o,
    output logic             bad_blk_o
);

    logic [SYNC_STAGES-1:0] rb_sync_q;
    logic                   req;
    bus_op_t                op;
    logic                   ack;
    logic [7:0]             rdata;
    logic                   tmr_en;
    logic                   wb_ok;
    logic                   expired;

    always_ff @(posedge clk) begin
        if (rst) begin
            rb_sync_q <= '0;
        end else begin
            rb_sync_q <= {rb_sync_q[SYNC_STAGES-2:0], rb_n_i};
        end
    end

    nand_erase_fsm #(
        .BLK_W(BLK_W),
        .PG_W (PG_W)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .start_i   (start_i),
        .blk_addr_i(blk_addr_i),
        .rb_rdy_i  (rb_sync_q[SYNC_STAGES-1]),
        .wb_ok_i   (wb_ok),
        .expired_i (expired),
        .ack_i     (ack),
        .rdata_i   (rdata),
        .req_o     (req),
        .op_o      (op),
        .tmr_en_o  (tmr_en),
        .busy_o    (busy_o),
        .done_o    (done_o),
        .pass_o    (pass_o),
        .bad_o     (bad_blk_o),
        .ce_n_o    (ce_n_o),
        .wp_n_o    (wp_n_o)
    );

    nand_bus_cycle #(
        .SETUP_CYC(SETUP_CYC),
        .PULSE_CYC(PULSE_CYC),
        .HOLD_CYC (HOLD_CYC)
    ) u_bus (
        .clk    (clk),
        .rst    (rst),
        .req_i  (req),
        .op_i   (op),
        .io_i   (io_i),
        .cle_o  (cle_o),
        .ale_o  (ale_o),
        .we_n_o (we_n_o),
        .re_n_o (re_n_o),
        .io_o   (io_o),
        .io_oe_o(io_oe_o),
        .rdata_o(rdata),
        .ack_o  (ack)
    );

    nand_busy_timer #(
        .WB_CYC     (WB_CYC),
        .TIMEOUT_CYC(TIMEOUT_CYC)
    ) u_tmr (
        .clk      (clk),
        .rst      (rst),
        .en_i     (tmr_en),
        .wb_ok_o  (wb_ok),
        .expired_o(expired)
    );

endmodule

// File: rtl/nand_blk_erase_chk.sv
module nand_blk_erase_chk (
    input logic       clk,
    input logic       rst,
    input logic [7:0] io_o,
    input logic       io_oe_o,
    input logic       cle_o,
    input logic       ale_o,
    input logic       we_n_o,
    input logic       re_n_o,
    input logic       busy_o,
    input logic       done_o,
    input logic       pass_o,
    input logic       bad_blk_o
);

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst) !(!we_n_o && !re_n_o)); // R10
    AST_LATCH_EXCL: assert property (@(posedge clk) disable iff (rst) !(cle_o && ale_o)); // R3
    AST_WE_SETUP: assert property (@(posedge clk) disable iff (rst) $fell(we_n_o) |-> ($stable(cle_o) && $stable(ale_o) && $stable(io_o))); // R4
    AST_WE_HOLD: assert property (@(posedge clk) disable iff (rst) $rose(we_n_o) |-> ($stable(cle_o) && $stable(ale_o) && $stable(io_o))); // R4
    AST_WRITE_DRIVES: assert property (@(posedge clk) disable iff (rst) !we_n_o |-> io_oe_o); // R10
    AST_READ_RELEASES: assert property (@(posedge clk) disable iff (rst) !re_n_o |-> !io_oe_o); // R10
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst) !busy_o |-> (we_n_o && re_n_o)); // R2
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst) done_o |=> !done_o); // R11
    AST_RETIRE_FAILS: assert property (@(posedge clk) disable iff (rst) (done_o && bad_blk_o) |-> !pass_o); // R7

endmodule

bind nand_blk_erase nand_blk_erase_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .io_o     (io_o),
    .io_oe_o  (io_oe_o),
    .cle_o    (cle_o),
    .ale_o    (ale_o),
    .we_n_o   (we_n_o),
    .re_n_o   (re_n_o),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .pass_o   (pass_o),
    .bad_blk_o(bad_blk_o)
);

// File: tb/sim_nand_blk_erase.sv
`timescale 1ns/1ps
module sim_nand_blk_erase;

    localparam int SETUP = 2;
    localparam int PULSE = 3;
    localparam int HOLD  = 2;
    localparam int WB    = 4;
    localparam int TOUT  = 3000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_i = 1'b0;
    logic [9:0] blk_addr_i = '0;
    logic       rb_n_i = 1'b1;
    logic [7:0] io_i;
    logic [7:0] io_o;
    logic       io_oe_o, cle_o, ale_o, ce_n_o, we_n_o, re_n_o, wp_n_o;
    logic       busy_o, done_o, pass_o, bad_blk_o;

    int checks = 0;
    int fails  = 0;

    logic [7:0] stat_byte = 8'h00;
    int         erase_len = 100;
    int         busy_left = 0;
    int         cyc = 0;
    int         rb_up_cyc = 0;
    int         re_count = 0;

    logic [7:0] lg_data [0:15];
    logic [1:0] lg_kind [0:15];
    int         lg_cyc  [0:15];
    int         lg_n = 0;

    always #2.5 clk = ~clk;

    assign io_i = (!re_n_o) ? stat_byte : 8'h00;

    nand_blk_erase #(
        .SETUP_CYC  (SETUP),
        .PULSE_CYC  (PULSE),
        .HOLD_CYC   (HOLD),
        .WB_CYC     (WB),
        .TIMEOUT_CYC(TOUT)
    ) u0 (
        .clk(clk), .rst(rst), .start_i(start_i), .blk_addr_i(blk_addr_i),
        .rb_n_i(rb_n_i), .io_i(io_i), .io_o(io_o), .io_oe_o(io_oe_o),
        .cle_o(cle_o), .ale_o(ale_o), .ce_n_o(ce_n_o), .we_n_o(we_n_o),
        .re_n_o(re_n_o), .wp_n_o(wp_n_o), .busy_o(busy_o), .done_o(done_o),
        .pass_o(pass_o), .bad_blk_o(bad_blk_o)
    );

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic logic exp_pass(input logic [7:0] st, input logic tout);
        return !tout && !st[0];
    endfunction

    function automatic logic [7:0] exp_row(input logic [9:0] blk, input logic hi);
        logic [15:0] row;
        row = {2'b00, blk, 4'b0000};
        return hi ? row[15:8] : row[7:0];
    endfunction

    // memory model and strobe timing monitor, both sampled away from the active edge
    logic       we_q = 1'b1;
    logic       re_q = 1'b1;
    logic [10:0] prev_sig = '0;
    int         stab = 0;
    int         low_cnt = 0;
    int         hold_cnt = 0;
    logic       hold_pend = 1'b0;

    always @(negedge clk) begin
        logic [10:0] cur;
        cyc++;
        if (!rst) begin
            cur = {cle_o, ale_o, io_oe_o, io_o};
            if (cur != prev_sig) begin
                if (hold_pend) begin
                    chk(hold_cnt >= HOLD, "R4 hold after we_n rise", hold_cnt, HOLD);
                    hold_pend = 1'b0;
                end
                stab = 0;
            end else begin
                stab++;
                if (hold_pend) hold_cnt++;
            end
            prev_sig = cur;
            if (we_q && !we_n_o) chk(stab >= SETUP, "R4 setup before we_n fall", stab, SETUP);
            if (!we_n_o) low_cnt++;
            if (!we_q && we_n_o) begin
                chk(low_cnt == PULSE, "R4 we_n pulse width", low_cnt, PULSE);
                low_cnt   = 0;
                hold_pend = 1'b1;
                hold_cnt  = 1;
                if (lg_n < 16) begin
                    lg_data[lg_n] = io_o;
                    lg_kind[lg_n] = {ale_o, cle_o};
                    lg_cyc[lg_n]  = cyc;
                    lg_n++;
                end
                if (cle_o && io_o == 8'hD0) begin
                    rb_n_i    = 1'b0;
                    busy_left = erase_len;
                end
            end
            if (re_q && !re_n_o) re_count++;
            if (busy_left > 0) begin
                busy_left--;
                if (busy_left == 0) begin
                    rb_n_i    = 1'b1;
                    rb_up_cyc = cyc;
                end
            end
        end
        we_q = we_n_o;
        re_q = re_n_o;
    end

    task automatic do_erase(input logic [9:0] blk, input int elen, input logic [7:0] st, input logic tout);
        int  waited;
        int  n_exp;
        logic [7:0] ed [0:4];
        logic [1:0] ek [0:4];
        lg_n      = 0;
        re_count  = 0;
        erase_len = elen;
        stat_byte = st;
        @(negedge clk);
        blk_addr_i = blk;
        start_i    = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o && wp_n_o && !ce_n_o, "R2 busy/wp_n/ce_n during op", {busy_o, wp_n_o, ce_n_o}, 3'b110);
        repeat (3) @(negedge clk);
        // R9: a second request with another block while busy
        blk_addr_i = ~blk;
        start_i    = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        waited = 0;
        while (!done_o && waited < 20000) begin
            @(negedge clk);
            waited++;
        end
        chk(done_o, "R11 done seen", done_o, 1);
        chk(pass_o == exp_pass(st, tout), "R6 R7 R8 pass flag", pass_o, exp_pass(st, tout));
        chk(bad_blk_o == (!tout && st[0]), "R7 R8 retire flag", bad_blk_o, !tout && st[0]);
        @(negedge clk);
        chk(!done_o, "R11 done one cycle", done_o, 0);
        chk(pass_o == exp_pass(st, tout) && bad_blk_o == (!tout && st[0]), "R11 flags held",
            {pass_o, bad_blk_o}, {exp_pass(st, tout), !tout && st[0]});
        chk(!busy_o && !wp_n_o && ce_n_o, "R2 idle after done", {busy_o, wp_n_o, ce_n_o}, 3'b001);
        ed[0] = 8'h60;            ek[0] = 2'b01;
        ed[1] = exp_row(blk, 0);  ek[1] = 2'b10;
        ed[2] = exp_row(blk, 1);  ek[2] = 2'b10;
        ed[3] = 8'hD0;            ek[3] = 2'b01;
        ed[4] = 8'h70;            ek[4] = 2'b01;
        n_exp = tout ? 4 : 5;
        chk(lg_n == n_exp, "R3 R8 R9 write cycle count", lg_n, n_exp);
        for (int i = 0; i < 5; i++) begin
            if (i < n_exp && i < lg_n) begin
                chk(lg_data[i] == ed[i] && lg_kind[i] == ek[i], "R3 R9 write cycle content",
                    {lg_kind[i], lg_data[i]}, {ek[i], ed[i]});
            end
        end
        if (!tout && lg_n == 5) begin
            chk(lg_cyc[4] > rb_up_cyc, "R5 status after ready", lg_cyc[4], rb_up_cyc);
            chk(lg_cyc[4] - lg_cyc[3] >= elen, "R5 wait covers busy time", lg_cyc[4] - lg_cyc[3], elen);
            chk(re_count == 1, "R10 one status read", re_count, 1);
        end
        if (tout) begin
            chk(re_count == 0, "R8 no status read", re_count, 0);
            while (!rb_n_i) @(negedge clk);
        end
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R11 watchdog act=running exp=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (4) @(negedge clk);
        chk(!cle_o && !ale_o && ce_n_o && we_n_o && re_n_o && !wp_n_o && !busy_o && !done_o,
            "R1 reset strobes", {cle_o, ale_o, ce_n_o, we_n_o, re_n_o, wp_n_o, busy_o, done_o}, 8'b00111000);
        rst = 1'b0;
        @(negedge clk);
        chk(!pass_o && !bad_blk_o && !busy_o, "R1 reset flags", {pass_o, bad_blk_o, busy_o}, 0);

        do_erase(10'd0,    30,  8'h00, 1'b0);   // R6 lowest block
        do_erase(10'd1023, 60,  8'h01, 1'b0);   // R7 highest block, error
        do_erase(10'h2A5,  15,  8'hFE, 1'b0);   // R6 upper status bits ignored
        do_erase(10'h155,  TOUT + 500, 8'h00, 1'b1); // R8 timeout
        do_erase(10'h0F0,  5,   8'hC1, 1'b0);   // R7 short busy
        for (int k = 0; k < 10; k++) begin
            logic [9:0] b;
            logic [7:0] s;
            int         e;
            b = 10'($urandom % 1024);
            s = 8'($urandom);
            e = 10 + int'($urandom % 400);
            do_erase(b, e, s, 1'b0);
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule